// File: doc/BRIEF.md
# Strobed Parallel Port Handshake Controller

This block links an 8-bit parallel pad bus to a CPU-side register pair. An external host moves bytes in and out through two buffers. Each buffer has a full flag, and two active-low strobes drive the handshake. The CPU writes an output byte, which raises the output-full flag. The host then pulses the output strobe to take the byte, and the chosen edge of that strobe clears the flag. In the other direction, the host presents a byte and pulses the input strobe. Depending on the mode, the byte is captured either transparently while the strobe is low or on its falling edge, and the input-full flag is set. A CPU read of the data register drops the flag.

A control/status register sets the latch style and the clearing edge. It also gives each of the two flag pins one of four roles: a fixed low output, a fixed high output, a copy of a buffer flag, or an input. As an input, the first pin chooses whether the data register or the status byte appears on the pads. The second pin gates the whole port on and off, so several devices can share one bus. All asynchronous pad controls pass through a synchronizer before any edge is detected. When a CPU access and a strobe edge touch the same flag in the same cycle, the CPU access wins.

Top module: `strobe_pport`

## Requirements
- R1: After reset the status register reads 0xFC: mode bits 7:2 are one and both flags (bit 0 input-full, bit 1 output-full) are zero. The pad drivers and both flag-pin drivers are off.
- R2: A CPU write to the status register (address 1) updates bits 7:2 only. Bits 1:0 are unaffected by that write.
- R3: With bit 2 = 0, the input buffer follows the pads while the synchronized input strobe is low and holds from its rising edge. That rising edge sets the input-full flag.
- R4: With bit 2 = 1, only a falling edge of the input strobe loads the input buffer and sets the input-full flag. A rising edge changes neither.
- R5: A CPU read of the data register (address 0) returns the input buffer and clears the input-full flag. The clear wins over a set in the same cycle.
- R6: A CPU write to the data register loads the output buffer and sets the output-full flag. The set wins over a clear in the same cycle, and nothing else sets the flag.
- R7: The output-full flag clears on the rising edge of the output strobe when bit 3 = 1, and on its falling edge when bit 3 = 0.
- R8: Bits 5:4 set the first flag pin. 00 drives low, 01 drives high, and 10 drives the output-full flag. 11 turns the driver off and uses the pin as a select: high shows the status byte on the pads and low shows the output buffer.
- R9: Bits 7:6 set the second flag pin. 00 drives low, 01 drives high, and 10 drives the input-full flag. 11 turns the driver off and uses the pin as a port enable: while it is high, both strobes are ignored and the pad drivers are off.
- R10: The pad drivers are on exactly while the synchronized output strobe is low and the port is enabled. The pads then carry the output buffer, or the status byte when selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_rd | input | 1 | One-cycle CPU read strobe |
| cpu_addr | input | 1 | 0 = data register, 1 = status register |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Combinational read data of the selected register |
| pad_din | input | DATA_W | Pad input data |
| pad_dout | output | DATA_W | Pad output data |
| pad_doe | output | 1 | Pad output driver enable |
| istb_n | input | 1 | Active-low input strobe |
| ostb_n | input | 1 | Active-low output strobe |
| fa_in | input | 1 | First flag pin, input value |
| fa_out | output | 1 | First flag pin, output value |
| fa_oe | output | 1 | First flag pin, driver enable |
| fb_in | input | 1 | Second flag pin, input value |
| fb_out | output | 1 | Second flag pin, output value |
| fb_oe | output | 1 | Second flag pin, driver enable |

## Verification
The assertions check the following on every cycle:
- a data write leaves the output-full flag set, and the flag never rises without one;
- a data read leaves the input-full flag clear;
- the input-full flag only rises one cycle after the synchronized input strobe changed;
- the pad drivers stay off while the port enable is high or the synchronized output strobe is high;
- the first flag pin floats in select mode.

Some behaviour only the directed scenarios can show. This covers transparent versus edge capture of the input data, which strobe edge clears the output flag in each mode, the status byte appearing on the pads, and the driven level of each flag pin in every mode. It also covers the cycle where a CPU access and a strobe edge coincide.

// File: rtl/spp_pkg.sv
package spp_pkg;

   // Role of a flag pin, two bits per pin in the control field
   typedef enum logic [1:0] {
      PIN_LOW   = 2'b00,
      PIN_HIGH  = 2'b01,
      PIN_FLAG  = 2'b10,
      PIN_INPUT = 2'b11
   } pin_mode_e;

   // Writable part of the control/status register, bits 7:2
   typedef struct packed {
      pin_mode_e b_mode;     // bits 7:6
      pin_mode_e a_mode;     // bits 5:4
      logic      clr_rise;   // bit 3
      logic      latch_fall; // bit 2
   } ctrl_t;

   localparam logic [5:0] CTRL_RST = 6'h3F;

endpackage

// File: rtl/spp_sync.sv
// Multi-bit chain of synchronizer flops with per-bit reset values
module spp_sync #(
   parameter int         N       = 4,
   parameter int         STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spp_sync: STAGES must be at least 2");
   end

   logic [N-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)        chain[s] <= RST_VAL;
         else if (s == 0)   chain[s] <= d;
         else               chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spp_edge.sv
// Edge detector on an already synchronized level
module spp_edge #(
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   output logic rise,
   output logic fall
);
   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= s;
   end

   assign rise = s & ~prev;
   assign fall = ~s & prev;
endmodule

// File: rtl/spp_flag_pin.sv
// One flag pin: fixed level, flag copy, or high-impedance input
module spp_flag_pin
   import spp_pkg::*;
(
   input  pin_mode_e mode,
   input  logic      flag,
   output logic      pin_out,
   output logic      pin_oe
);
   always_comb begin
      pin_out = 1'b0;
      pin_oe  = 1'b1;
      unique case (mode)
         PIN_LOW:   pin_out = 1'b0;
         PIN_HIGH:  pin_out = 1'b1;
         PIN_FLAG:  pin_out = flag;
         PIN_INPUT: pin_oe  = 1'b0;
         default:   pin_oe  = 1'b0;
      endcase
   end
endmodule

// File: rtl/spp_in_buf.sv
// Input buffer with level (transparent) or falling-edge capture
module spp_in_buf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         latch_fall,
   input  logic         enabled,
   input  logic         stb_s,
   input  logic         stb_rise,
   input  logic         stb_fall,
   input  logic [W-1:0] din,
   input  logic         cpu_take,
   output logic [W-1:0] buf_q,
   output logic         full_q
);
   logic load, set_full;

   always_comb begin
      if (latch_fall) begin
         load     = enabled & stb_fall;
         set_full = enabled & stb_fall;
      end else begin
         load     = enabled & ~stb_s;
         set_full = enabled & stb_rise;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (load) buf_q <= din;
         if (cpu_take)      full_q <= 1'b0;  // CPU read wins
         else if (set_full) full_q <= 1'b1;
      end
   end
endmodule

// File: rtl/spp_out_buf.sv
// Output buffer with selectable clearing edge
module spp_out_buf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_rise,
   input  logic         enabled,
   input  logic         stb_rise,
   input  logic         stb_fall,
   input  logic         cpu_load,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] buf_q,
   output logic         full_q
);
   logic clr_edge;

   assign clr_edge = enabled & (clr_rise ? stb_rise : stb_fall);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (cpu_load)      buf_q  <= wdata;
         if (cpu_load)      full_q <= 1'b1;  // CPU write wins
         else if (clr_edge) full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/strobe_pport.sv
module strobe_pport
   import spp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic              cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] pad_din,
   output logic [DATA_W-1:0] pad_dout,
   output logic              pad_doe,
   input  logic              istb_n,
   input  logic              ostb_n,
   input  logic              fa_in,
   output logic              fa_out,
   output logic              fa_oe,
   input  logic              fb_in,
   output logic              fb_out,
   output logic              fb_oe
);
   localparam int         NSYNC    = 4;
   // bit order: 0 input strobe, 1 output strobe, 2 first pin, 3 second pin
   localparam logic [NSYNC-1:0] SYNC_RST = 4'b1011;
   localparam int         STAT_W   = 8;

   if (DATA_W < STAT_W) begin : g_bad_width
      $error("strobe_pport: DATA_W must hold the 8-bit status byte");
   end

   logic [NSYNC-1:0] sync_q;
   logic [1:0]       stb_rise, stb_fall;
   logic             istb_s, ostb_s, fa_s, fb_s;
   ctrl_t            ctrl_q;
   logic             ibf_q, obf_q;
   logic             enabled, show_status;
   logic [DATA_W-1:0] in_buf, out_buf, status_ext;
   logic [STAT_W-1:0] status;

   spp_sync #(.N(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({fb_in, fa_in, ostb_n, istb_n}),
      .q(sync_q)
   );

   assign istb_s = sync_q[0];
   assign ostb_s = sync_q[1];
   assign fa_s   = sync_q[2];
   assign fb_s   = sync_q[3];

   for (genvar i = 0; i < 2; i++) begin : g_edge
      spp_edge #(.RST_VAL(SYNC_RST[i])) u_edge (
         .clk(clk), .rst_n(rst_n), .s(sync_q[i]),
         .rise(stb_rise[i]), .fall(stb_fall[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  ctrl_q <= ctrl_t'(CTRL_RST);
      else if (cpu_wr && cpu_addr) ctrl_q <= ctrl_t'(cpu_wdata[STAT_W-1:2]);
   end

   assign enabled = !((ctrl_q.b_mode == PIN_INPUT) && fb_s);

   spp_in_buf #(.W(DATA_W)) u_in (
      .clk(clk), .rst_n(rst_n),
      .latch_fall(ctrl_q.latch_fall), .enabled(enabled),
      .stb_s(istb_s), .stb_rise(stb_rise[0]), .stb_fall(stb_fall[0]),
      .din(pad_din), .cpu_take(cpu_rd && !cpu_addr),
      .buf_q(in_buf), .full_q(ibf_q)
   );

   spp_out_buf #(.W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .clr_rise(ctrl_q.clr_rise), .enabled(enabled),
      .stb_rise(stb_rise[1]), .stb_fall(stb_fall[1]),
      .cpu_load(cpu_wr && !cpu_addr), .wdata(cpu_wdata),
      .buf_q(out_buf), .full_q(obf_q)
   );

   spp_flag_pin u_fa (.mode(ctrl_q.a_mode), .flag(obf_q), .pin_out(fa_out), .pin_oe(fa_oe));
   spp_flag_pin u_fb (.mode(ctrl_q.b_mode), .flag(ibf_q), .pin_out(fb_out), .pin_oe(fb_oe));

   assign status = {ctrl_q, obf_q, ibf_q};

   always_comb begin
      status_ext = '0;
      status_ext[STAT_W-1:0] = status;
   end

   assign show_status = (ctrl_q.a_mode == PIN_INPUT) && fa_s;
   assign pad_dout    = show_status ? status_ext : out_buf;
   assign pad_doe     = enabled && !ostb_s;
   assign cpu_rdata   = cpu_addr ? status_ext : in_buf;

endmodule

// File: rtl/strobe_pport_chk.sv
module strobe_pport_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_wr,
   input logic       cpu_rd,
   input logic       cpu_addr,
   input logic       ibf,
   input logic       obf,
   input logic       istb_s,
   input logic       ostb_s,
   input logic       fb_s,
   input logic [1:0] a_mode,
   input logic [1:0] b_mode,
   input logic       fa_oe,
   input logic       pad_doe
);
   AST_OBF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !cpu_addr) |=> obf); // R6
   AST_OBF_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!obf && !(cpu_wr && !cpu_addr)) |=> !obf); // R6
   AST_IBF_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !cpu_addr) |=> !ibf); // R5
   AST_IBF_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ibf) |-> ($past(istb_s, 1) != $past(istb_s, 2))); // R4
   AST_PE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (b_mode == 2'b11 && fb_s) |-> !pad_doe); // R9
   AST_DOE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      pad_doe |-> !ostb_s); // R10
   AST_SEL_PIN_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (a_mode == 2'b11) |-> !fa_oe); // R8
endmodule

bind strobe_pport strobe_pport_chk i_chk (
   .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
   .ibf(ibf_q), .obf(obf_q), .istb_s(istb_s), .ostb_s(ostb_s), .fb_s(fb_s),
   .a_mode(ctrl_q.a_mode), .b_mode(ctrl_q.b_mode), .fa_oe(fa_oe), .pad_doe(pad_doe)
);

// File: tb/test_strobe_pport.sv
`timescale 1ns/1ps
module test_strobe_pport;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_addr = 1'b0;
   logic [7:0] cpu_wdata = '0, pad_din = '0;
   logic [7:0] cpu_rdata, pad_dout;
   logic       pad_doe, fa_out, fa_oe, fb_out, fb_oe;
   logic       istb_n = 1'b1, ostb_n = 1'b1, fa_in = 1'b0, fb_in = 1'b0;
   int         checks = 0, errors = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   strobe_pport i_strobe_pport (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pad_din(pad_din), .pad_dout(pad_dout),
      .pad_doe(pad_doe), .istb_n(istb_n), .ostb_n(ostb_n), .fa_in(fa_in), .fa_out(fa_out),
      .fa_oe(fa_oe), .fb_in(fb_in), .fb_out(fb_out), .fb_oe(fb_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cpu_write(input logic a, input logic [7:0] d);
      @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic a, output logic [7:0] d);
      @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk); cpu_rd = 1'b0;
   endtask

   // Strobe edge timed so its detected edge lands in the same cycle as a CPU access
   task automatic strobe_with_cpu(input bit in_side, input logic lvl, input bit do_rd, input logic [7:0] d);
      @(negedge clk);
      if (in_side) istb_n = lvl; else ostb_n = lvl;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      if (do_rd) begin cpu_rd = 1'b1; cpu_addr = 1'b0; end
      else begin cpu_wr = 1'b1; cpu_addr = 1'b0; cpu_wdata = d; end
      @(negedge clk); cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      wait_clk(2);
      chk("R1 doe", pad_doe, 0);
      chk("R1 fa_oe", fa_oe, 0);
      chk("R1 fb_oe", fb_oe, 0);
      cpu_read(1'b1, v);
      chk("R1 status", v, 8'hFC);
   endtask

   task automatic t_ctrl_ro;
      logic [7:0] v;
      cpu_write(1'b1, 8'h00);
      cpu_read(1'b1, v);
      chk("R2 mode bits written", v, 8'h00);
      cpu_write(1'b0, 8'h5A);
      cpu_read(1'b1, v);
      chk("R6 obf set by write", v, 8'h02);
      cpu_write(1'b1, 8'h00);
      cpu_read(1'b1, v);
      chk("R2 flags read-only", v, 8'h02);
   endtask

   task automatic t_flag_pins;
      wait_clk(1);
      chk("R8 a low", {fa_oe, fa_out}, 2'b10);
      chk("R9 b low", {fb_oe, fb_out}, 2'b10);
      cpu_write(1'b1, 8'h50);
      wait_clk(1);
      chk("R8 a high", {fa_oe, fa_out}, 2'b11);
      chk("R9 b high", {fb_oe, fb_out}, 2'b11);
      cpu_write(1'b1, 8'hA0);
      wait_clk(1);
      chk("R8 a shows obf", fa_out, 1);
      chk("R9 b shows ibf", fb_out, 0);
   endtask

   task automatic t_output;
      ostb_n = 1'b0; wait_clk(5);
      chk("R10 doe on", pad_doe, 1);
      chk("R10 dout", pad_dout, 8'h5A);
      chk("R7 falling clears", fa_out, 0);
      ostb_n = 1'b1; wait_clk(5);
      chk("R10 doe off", pad_doe, 0);
      cpu_write(1'b1, 8'hA8);
      cpu_write(1'b0, 8'h33);
      ostb_n = 1'b0; wait_clk(5);
      chk("R7 falling keeps in rise mode", fa_out, 1);
      chk("R10 dout new", pad_dout, 8'h33);
      ostb_n = 1'b1; wait_clk(5);
      chk("R7 rising clears", fa_out, 0);
   endtask

   task automatic t_level;
      logic [7:0] v;
      cpu_write(1'b1, 8'hA0);
      pad_din = 8'h11; istb_n = 1'b0; wait_clk(5);
      pad_din = 8'h22; wait_clk(5);
      chk("R3 no flag while low", fb_out, 0);
      istb_n = 1'b1; wait_clk(5);
      chk("R3 rise sets ibf", fb_out, 1);
      pad_din = 8'h99; wait_clk(5);
      cpu_read(1'b0, v);
      chk("R3 held value", v, 8'h22);
      wait_clk(1);
      chk("R5 read clears ibf", fb_out, 0);
   endtask

   task automatic t_edge;
      logic [7:0] v;
      cpu_write(1'b1, 8'hA4);
      pad_din = 8'h44; istb_n = 1'b0; wait_clk(5);
      chk("R4 fall sets ibf", fb_out, 1);
      pad_din = 8'h55; wait_clk(5);
      cpu_read(1'b0, v);
      chk("R4 captured at fall", v, 8'h44);
      istb_n = 1'b1; wait_clk(5);
      chk("R4 rise ignored", fb_out, 0);
      cpu_read(1'b0, v);
      chk("R4 buffer unchanged on rise", v, 8'h44);
   endtask

   task automatic t_priority;
      strobe_with_cpu(1'b1, 1'b0, 1'b1, 8'h00);
      wait_clk(3);
      chk("R5 read beats set", fb_out, 0);
      istb_n = 1'b1; wait_clk(5);
      cpu_write(1'b0, 8'h77);
      strobe_with_cpu(1'b0, 1'b0, 1'b0, 8'h78);
      wait_clk(3);
      chk("R6 write beats clear", fa_out, 1);
      chk("R6 new data", pad_dout, 8'h78);
      ostb_n = 1'b1; wait_clk(5);
      ostb_n = 1'b0; wait_clk(5);
      chk("R7 next falling clears", fa_out, 0);
   endtask

   task automatic t_select;
      cpu_write(1'b1, 8'hF0);
      fa_in = 1'b1; wait_clk(5);
      chk("R8 select pin floats", fa_oe, 0);
      chk("R8 status on pads", pad_dout, 8'hF0);
      fa_in = 1'b0; wait_clk(5);
      chk("R8 data on pads", pad_dout, 8'h78);
   endtask

   task automatic t_port_enable;
      logic [7:0] v;
      fb_in = 1'b1; wait_clk(5);
      chk("R9 drivers off when disabled", pad_doe, 0);
      chk("R9 pin floats", fb_oe, 0);
      cpu_write(1'b0, 8'h12);
      ostb_n = 1'b1; wait_clk(5);
      ostb_n = 1'b0; wait_clk(5);
      istb_n = 1'b0; wait_clk(5);
      istb_n = 1'b1; wait_clk(5);
      cpu_read(1'b1, v);
      chk("R9 strobes ignored", v, 8'hF2);
      fb_in = 1'b0; ostb_n = 1'b1; wait_clk(5);
      ostb_n = 1'b0; wait_clk(5);
      cpu_read(1'b1, v);
      chk("R9 re-enabled clears", v, 8'hF0);
      chk("R10 doe on again", pad_doe, 1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      t_reset();
      t_ctrl_ro();
      t_flag_pins();
      t_output();
      t_level();
      t_edge();
      t_priority();
      t_select();
      t_port_enable();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule